// File: doc/BRIEF.md
# Hashed Term Match-Accumulate Array

This block scores a stream of query terms against a stored dictionary for a linear text classifier. The dictionary is a grid of cells: each row stands for one class, and each cell in a row holds a 64-bit term hash and a 64-bit weight. Every row also holds a constant offset. A query is a term hash plus a frequency. The block sends each query to every cell at the same time. A cell whose stored hash equals the query hash yields weight × frequency, and every other cell yields zero. Each row adds up its cell results into a per-query contribution. That contribution is then added to the row's running class score.

A scoring run is a sequence of queries, and its last query is flagged. For every query, the largest row contribution is also added to a run total. When the flagged query has been applied, the block presents three results: the final score of every class, the index of the best class, and the run total. All arithmetic is unsigned, and every sum clamps at the largest 64-bit value instead of wrapping. The dictionary and the row offsets are written through a simple load port. Producing the term hashes from text happens upstream of this block.

Top module: `term_score_array`

## Requirements
- R1: After reset, q_ready is 1, res_valid is 0, and res_class, res_total and every score in res_scores are 0.
- R2: For each accepted query, every cell whose stored hash equals q_hash contributes its weight times q_freq, truncated to the low 64 bits. A cell whose hash differs contributes 0. All rows see the same query.
- R3: The score of a row is its offset plus the sum of its per-query contributions over the run. The offset is applied again at the start of every run.
- R4: The per-query row sum, the row score and the run total saturate at 64'hFFFF_FFFF_FFFF_FFFF instead of wrapping.
- R5: A query is accepted on a rising edge where q_valid and q_ready are both 1. q_ready is then 0 for the next two cycles. While q_ready is 0, the query inputs have no effect.
- R6: For each query, the largest per-query row sum is added to the run total. The run total restarts from 0 with every run.
- R7: When an accepted query has q_last = 1, res_valid is 1 for exactly one cycle, starting just after the third rising edge that follows the accepting edge. q_ready stays 0 until that same edge. The next run starts with the next accepted query.
- R8: res_class is the index of the row with the largest final score. When scores are equal, the lowest index wins.
- R9: While ld_en = 1 and ld_bias = 0, a clock edge writes ld_hash and ld_value into cell ld_cell of row ld_row. While ld_en = 1 and ld_bias = 1, a clock edge writes ld_value as the offset of row ld_row. A load changes no score or result by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Dictionary write strobe |
| ld_bias | input | 1 | 1: write a row offset; 0: write a cell |
| ld_row | input | RIDX_W | Row (class) to write |
| ld_cell | input | CIDX_W | Cell within the row to write |
| ld_hash | input | W | Term hash for a cell write |
| ld_value | input | W | Weight for a cell write, or the offset for a row write |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Block can accept a query |
| q_hash | input | W | Query term hash |
| q_freq | input | W | Query term frequency |
| q_last | input | 1 | Marks the final query of a run |
| res_valid | output | 1 | One-cycle pulse: results updated |
| res_class | output | RIDX_W | Index of the best class |
| res_total | output | W | Run total of the best per-query contributions |
| res_scores | output | NUM_ROWS*W | Final class scores; row r occupies bits [r*W +: W] |

## Verification
A query accepted on edge E0 has its cell products registered at E1. The row scores and the run total are updated at E2. For a flagged query, the results are registered at E3. The driver samples on falling edges. It confirms that q_ready is low after E0 and after E1. For a flagged query, it also confirms that res_valid is low after E0, E1 and E2 and high after E3. The driver pushes the expected scores, class and total into a scoreboard queue when it starts a run. A monitor pops one entry on each falling edge where res_valid is high. During every busy cycle, the driver holds q_valid high with a conflicting query, so any early acceptance would alter the compared results.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MATCH = 2'd1,
      ST_SUM   = 2'd2,
      ST_FIN   = 2'd3
   } tsa_state_e;

   localparam int TSA_DEF_W     = 64;
   localparam int TSA_DEF_ROWS  = 4;
   localparam int TSA_DEF_CELLS = 8;
endpackage

// File: rtl/tsa_cell.sv
module tsa_cell #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_hash,
   input  logic [W-1:0] wr_weight,
   input  logic [W-1:0] q_hash,
   input  logic [W-1:0] q_freq,
   input  logic         eval,
   output logic [W-1:0] prod
);
   logic [W-1:0] key_r;
   logic [W-1:0] wgt_r;
   logic [W-1:0] mul_trunc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_r <= '0;
         wgt_r <= '0;
      end else if (wr_en) begin
         key_r <= wr_hash;
         wgt_r <= wr_weight;
      end
   end

   assign mul_trunc = wgt_r * q_freq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prod <= '0;
      else if (eval)
         prod <= (key_r == q_hash) ? mul_trunc : '0;
   end

   // R2: a cell whose key differs from the query yields zero
   assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && (key_r != q_hash)) |=> (prod == '0));

   // R5: the product holds between evaluations
   assert_prod_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> $stable(prod));
endmodule

// File: rtl/tsa_row.sv
module tsa_row #(
   parameter int NCELL  = 8,
   parameter int W      = 64,
   parameter int CIDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cell_en,
   input  logic              wr_bias_en,
   input  logic [CIDX_W-1:0] wr_cell,
   input  logic [W-1:0]      wr_hash,
   input  logic [W-1:0]      wr_value,
   input  logic [W-1:0]      q_hash,
   input  logic [W-1:0]      q_freq,
   input  logic              eval,
   input  logic              apply,
   input  logic              fresh,
   output logic [W-1:0]      part,
   output logic [W-1:0]      score
);
   function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[W] ? {W{1'b1}} : s[W-1:0];
   endfunction

   logic [W-1:0] prod  [NCELL];
   logic [W-1:0] chain [NCELL+1];
   logic [W-1:0] bias_r;

   assign chain[0] = '0;

   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      logic sel;
      assign sel = wr_cell_en && (wr_cell == CIDX_W'(c));
      tsa_cell #(.W(W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (sel),
         .wr_hash   (wr_hash),
         .wr_weight (wr_value),
         .q_hash    (q_hash),
         .q_freq    (q_freq),
         .eval      (eval),
         .prod      (prod[c])
      );
      assign chain[c+1] = sat_add(chain[c], prod[c]);
   end

   assign part = chain[NCELL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bias_r <= '0;
      else if (wr_bias_en)
         bias_r <= wr_value;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         score <= '0;
      else if (apply)
         score <= sat_add(fresh ? bias_r : score, part);
   end

   // R4: within a run a score never falls (saturating, no wrap)
   assert_score_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !fresh) |=> (score >= $past(score)));

   // R3: scores move only when a query is applied
   assert_score_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(score));
endmodule

// File: rtl/tsa_argmax.sv
module tsa_argmax #(
   parameter int N  = 4,
   parameter int W  = 64,
   parameter int IW = 2
) (
   input  logic [N*W-1:0] vals,
   output logic [IW-1:0]  idx,
   output logic [W-1:0]   max
);
   if (N == 1) begin : g_single
      assign idx = '0;
      assign max = vals[W-1:0];
   end else begin : g_scan
      always_comb begin
         max = vals[W-1:0];
         idx = '0;
         for (int i = 1; i < N; i++) begin
            if (vals[i*W +: W] > max) begin
               max = vals[i*W +: W];
               idx = IW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/term_score_array.sv
module term_score_array
   import tsa_pkg::*;
#(
   parameter int W         = TSA_DEF_W,
   parameter int NUM_ROWS  = TSA_DEF_ROWS,
   parameter int NUM_CELLS = TSA_DEF_CELLS,
   parameter int RIDX_W    = (NUM_ROWS  > 1) ? $clog2(NUM_ROWS)  : 1,
   parameter int CIDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_en,
   input  logic                  ld_bias,
   input  logic [RIDX_W-1:0]     ld_row,
   input  logic [CIDX_W-1:0]     ld_cell,
   input  logic [W-1:0]          ld_hash,
   input  logic [W-1:0]          ld_value,
   input  logic                  q_valid,
   output logic                  q_ready,
   input  logic [W-1:0]          q_hash,
   input  logic [W-1:0]          q_freq,
   input  logic                  q_last,
   output logic                  res_valid,
   output logic [RIDX_W-1:0]     res_class,
   output logic [W-1:0]          res_total,
   output logic [NUM_ROWS*W-1:0] res_scores
);
   localparam int FLAT_W = NUM_ROWS * W;

   if (W < 8) begin : g_bad_w
      $error("term_score_array: W must be at least 8");
   end
   if (NUM_ROWS < 1 || NUM_CELLS < 1) begin : g_bad_dim
      $error("term_score_array: NUM_ROWS and NUM_CELLS must be positive");
   end
   if (NUM_ROWS * NUM_CELLS > 1024) begin : g_bad_size
      $error("term_score_array: array larger than 1024 cells");
   end

   function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[W] ? {W{1'b1}} : s[W-1:0];
   endfunction

   tsa_state_e    state;
   logic [W-1:0]  qh_r;
   logic [W-1:0]  qf_r;
   logic          ql_r;
   logic          fresh;
   logic [W-1:0]  total;
   logic          accept;
   logic          eval;
   logic          apply;

   logic [FLAT_W-1:0] part_flat;
   logic [FLAT_W-1:0] score_flat;
   logic [W-1:0]      max_part;
   logic [RIDX_W-1:0] max_part_idx;
   logic [W-1:0]      max_score;
   logic [RIDX_W-1:0] best_idx;

   assign q_ready = (state == ST_IDLE);
   assign accept  = q_valid && q_ready;
   assign eval    = (state == ST_MATCH);
   assign apply   = (state == ST_SUM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qh_r <= '0;
         qf_r <= '0;
         ql_r <= 1'b0;
      end else if (accept) begin
         qh_r <= q_hash;
         qf_r <= q_freq;
         ql_r <= q_last;
      end
   end

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic row_sel;
      assign row_sel = ld_en && (ld_row == RIDX_W'(r));
      tsa_row #(.NCELL(NUM_CELLS), .W(W), .CIDX_W(CIDX_W)) u_row (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_cell_en (row_sel && !ld_bias),
         .wr_bias_en (row_sel && ld_bias),
         .wr_cell    (ld_cell),
         .wr_hash    (ld_hash),
         .wr_value   (ld_value),
         .q_hash     (qh_r),
         .q_freq     (qf_r),
         .eval       (eval),
         .apply      (apply),
         .fresh      (fresh),
         .part       (part_flat[r*W +: W]),
         .score      (score_flat[r*W +: W])
      );
   end

   tsa_argmax #(.N(NUM_ROWS), .W(W), .IW(RIDX_W)) u_part_max (
      .vals (part_flat),
      .idx  (max_part_idx),
      .max  (max_part)
   );

   tsa_argmax #(.N(NUM_ROWS), .W(W), .IW(RIDX_W)) u_score_max (
      .vals (score_flat),
      .idx  (best_idx),
      .max  (max_score)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         fresh      <= 1'b1;
         total      <= '0;
         res_valid  <= 1'b0;
         res_class  <= '0;
         res_total  <= '0;
         res_scores <= '0;
      end else begin
         res_valid <= 1'b0;
         unique case (state)
            ST_IDLE:  if (accept) state <= ST_MATCH;
            ST_MATCH: state <= ST_SUM;
            ST_SUM: begin
               total <= sat_add(fresh ? '0 : total, max_part);
               fresh <= 1'b0;
               state <= ql_r ? ST_FIN : ST_IDLE;
            end
            ST_FIN: begin
               res_scores <= score_flat;
               res_class  <= best_idx;
               res_total  <= total;
               res_valid  <= 1'b1;
               fresh      <= 1'b1;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: no new query in the two cycles after an acceptance
   assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !q_ready);

   // R7: the flagged query produces a result three edges after its acceptance
   assert_result_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && q_last) |-> ##4 res_valid);

   // R7: result strobe lasts a single cycle
   assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R6: the run total only grows inside a run
   assert_total_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !fresh) |=> (total >= $past(total)));

   // R8: the reported class holds the highest score
   assert_best_is_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_scores[res_class*W +: W] == $past(max_score)));
endmodule

// File: tb/term_score_array_bench.sv
module term_score_array_bench;
   localparam int NR = 4;
   localparam int NC = 8;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] JUNK_HASH = 64'h0000_0003_C0DE_0000;

   typedef struct packed {
      logic [NR*64-1:0] sc;
      logic [63:0]      tot;
      logic [1:0]       cls;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ld_en = 1'b0, ld_bias = 1'b0;
   logic [1:0]      ld_row = '0;
   logic [2:0]      ld_cell = '0;
   logic [63:0]     ld_hash = '0, ld_value = '0;
   logic            q_valid = 1'b0, q_last = 1'b0;
   logic [63:0]     q_hash = '0, q_freq = '0;
   logic            q_ready, res_valid;
   logic [1:0]      res_class;
   logic [63:0]     res_total;
   logic [NR*64-1:0] res_scores;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] m_hash [NR][NC];
   logic [63:0] m_wt   [NR][NC];
   logic [63:0] m_bias [NR];
   logic [63:0] qh [$];
   logic [63:0] qf [$];
   exp_t sb_q [$];
   exp_t last_exp;

   always #5 clk = ~clk;

   term_score_array u_term_score_array (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_bias(ld_bias), .ld_row(ld_row),
      .ld_cell(ld_cell), .ld_hash(ld_hash), .ld_value(ld_value), .q_valid(q_valid),
      .q_ready(q_ready), .q_hash(q_hash), .q_freq(q_freq), .q_last(q_last),
      .res_valid(res_valid), .res_class(res_class), .res_total(res_total),
      .res_scores(res_scores)
   );

   function automatic logic [63:0] sat64(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[64] ? ONES : s[63:0];
   endfunction

   function automatic logic [63:0] hcell(input int r, input int c);
      return {32'hC0DE_0000 + 32'(r), 32'(c)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_cell(input int r, input int c, input logic [63:0] h, input logic [63:0] w);
      @(negedge clk);
      ld_en = 1'b1; ld_bias = 1'b0; ld_row = 2'(r); ld_cell = 3'(c);
      ld_hash = h; ld_value = w;
      m_hash[r][c] = h; m_wt[r][c] = w;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load_bias(input int r, input logic [63:0] b);
      @(negedge clk);
      ld_en = 1'b1; ld_bias = 1'b1; ld_row = 2'(r); ld_value = b;
      m_bias[r] = b;
      @(negedge clk);
      ld_en = 1'b0; ld_bias = 1'b0;
   endtask

   task automatic send_query(input logic [63:0] h, input logic [63:0] f, input bit last);
      @(negedge clk);
      while (!q_ready) @(negedge clk);
      q_valid = 1'b1; q_hash = h; q_freq = f; q_last = last;
      @(negedge clk);                                   // after accepting edge
      chk("R5 ready low 1 cycle after accept", 64'(q_ready), 64'd0);
      if (last) chk("R7 no result after E0", 64'(res_valid), 64'd0);
      q_hash = JUNK_HASH; q_freq = 64'd977; q_last = 1'b1; // ignored while busy (R5)
      @(negedge clk);
      chk("R5 ready low 2 cycles after accept", 64'(q_ready), 64'd0);
      if (last) chk("R7 no result after E1", 64'(res_valid), 64'd0);
      @(negedge clk);
      q_valid = 1'b0; q_last = 1'b0;
      if (last) begin
         chk("R7 no result after E2", 64'(res_valid), 64'd0);
         chk("R7 ready low while finishing", 64'(q_ready), 64'd0);
         @(negedge clk);
         chk("R7 result after E3", 64'(res_valid), 64'd1);
         chk("R7 ready back after result", 64'(q_ready), 64'd1);
      end
   endtask

   // model of R2..R8 for the queries in qh/qf; pushes one expected item
   task automatic run_stream();
      exp_t e;
      logic [63:0] sc [NR];
      logic [63:0] part, mx, tot;
      int n;
      tot = '0;
      for (int r = 0; r < NR; r++) sc[r] = m_bias[r];
      n = qh.size();
      for (int i = 0; i < n; i++) begin
         mx = '0;
         for (int r = 0; r < NR; r++) begin
            part = '0;
            for (int c = 0; c < NC; c++)
               if (m_hash[r][c] == qh[i]) part = sat64(part, m_wt[r][c] * qf[i]);
            sc[r] = sat64(sc[r], part);
            if (part > mx) mx = part;
         end
         tot = sat64(tot, mx);
      end
      e.cls = 2'd0;
      for (int r = 1; r < NR; r++) if (sc[r] > sc[e.cls]) e.cls = 2'(r);
      for (int r = 0; r < NR; r++) e.sc[r*64 +: 64] = sc[r];
      e.tot = tot;
      sb_q.push_back(e);
      last_exp = e;
      for (int i = 0; i < n; i++) send_query(qh[i], qf[i], i == n - 1);
      qh.delete();
      qf.delete();
   endtask

   // monitor: compare each result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         exp_t e;
         if (sb_q.size() == 0) begin
            chk("R7 unexpected result strobe", 64'(res_valid), 64'd0);
         end else begin
            e = sb_q.pop_front();
            for (int r = 0; r < NR; r++)
               chk($sformatf("R3 score row %0d", r), res_scores[r*64 +: 64], e.sc[r*64 +: 64]);
            chk("R6 run total", res_total, e.tot);
            chk("R8 best class", 64'(res_class), 64'(e.cls));
         end
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) begin
         m_bias[r] = '0;
         for (int c = 0; c < NC; c++) begin m_hash[r][c] = '0; m_wt[r][c] = '0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset ready", 64'(q_ready), 64'd1);
      chk("R1 reset res_valid", 64'(res_valid), 64'd0);
      chk("R1 reset class", 64'(res_class), 64'd0);
      chk("R1 reset total", res_total, 64'd0);
      for (int r = 0; r < NR; r++) chk("R1 reset score", res_scores[r*64 +: 64], 64'd0);

      // R9: load dictionary; cell 7 of every row shares one hash
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < NC - 1; c++) load_cell(r, c, hcell(r, c), 64'(r * 10 + c + 1));
         load_cell(r, NC - 1, 64'h5A5A_5A5A_0000_0007, 64'((r + 1) * 3));
         load_bias(r, 64'(r * 5));
      end
      chk("R9 load leaves results untouched", 64'(res_valid), 64'd0);

      // R2/R3/R6: mixed hits, shared hit, miss
      qh.push_back(hcell(1, 2));             qf.push_back(64'd3);
      qh.push_back(64'h5A5A_5A5A_0000_0007); qf.push_back(64'd2);
      qh.push_back(hcell(3, 0));             qf.push_back(64'd1);
      qh.push_back(64'h1234);                qf.push_back(64'd9);
      qh.push_back(hcell(0, 5));             qf.push_back(64'd4);
      run_stream();
      chk("R8 best class stream one", 64'(res_class), 64'd3);
      chk("R6 total stream one", res_total, 64'd118);
      chk("R2 shared-hash row 2 score", res_scores[2*64 +: 64], 64'd28);

      // R3: a new run restarts from the offsets, total from zero
      qh.push_back(64'h9999); qf.push_back(64'd1);
      run_stream();
      chk("R3 offsets reapplied row 3", res_scores[3*64 +: 64], 64'd15);
      chk("R6 total restarts", res_total, 64'd0);

      // R8: tie between rows 1 and 2 goes to row 1
      load_bias(0, 64'd0); load_bias(1, 64'd100); load_bias(2, 64'd100); load_bias(3, 64'd0);
      qh.push_back(64'h7777); qf.push_back(64'd5);
      run_stream();
      chk("R8 tie lowest index", 64'(res_class), 64'd1);

      // R2 truncation and R4 saturation
      load_cell(2, 0, 64'hABCD, 64'hFFFF_FFFF_FFFF_FFF0);
      load_cell(2, 1, 64'hABCD, 64'h20);
      load_cell(1, 0, 64'hABCD, 64'h8000_0000_0000_0003);
      qh.push_back(64'hABCD); qf.push_back(64'd2);
      qh.push_back(64'hABCD); qf.push_back(64'd2);
      run_stream();
      chk("R4 saturated row score", res_scores[2*64 +: 64], ONES);
      chk("R4 saturated total", res_total, ONES);
      chk("R2 truncated product row 1", res_scores[1*64 +: 64], 64'd112);
      chk("R8 saturated row wins", 64'(res_class), 64'd2);

      repeat (4) @(negedge clk);
      chk("R7 all results seen", 64'(sb_q.size()), 64'd0);
      chk("R7 strobe stays low when idle", 64'(res_valid), 64'd0);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule